// File: doc/BRIEF.md
# Phased-Array Wrapped Delay Generator

This block assigns a start time slot to each channel of a sixteen-channel ultrasound transmit array. One ultrasound period is split into sixteen equal slots. A steering step, counted in slots, sets the delay between neighbouring channels. Each delay is wrapped into one period, so every channel's start falls somewhere in slots 0 to 15. A per-channel drive sequencer reads the resulting slot indices.

For any nonzero step, no two channels may start in the same slot. This lets each intermediate drive level pair exactly one charging channel with one discharging channel. The channels are walked in order. If a channel's plain wrapped delay lands on a slot that an earlier channel already holds, the block pulls that channel back one slot at a time until it reaches a free slot. Later channels then build on the adjusted value. The result is a permutation of the sixteen slots.

A step of zero means broadside: every channel gets slot 0. A direction input reverses the walk, so channel 15 is treated as the first. The work is sequential, one channel per clock. A done flag reports that the set of results is complete.

Top module: `phased_delay_gen`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every slot output is 0.
- R2: A `start` pulse seen while not busy captures `step` and `dir_neg`, clears all slot outputs and raises `busy` for exactly 16 clock cycles. After that, `busy` falls and `done` stays 1.
- R3: The first channel in walk order gets slot 0. Every later channel first tries the previous channel's final slot plus `step`, modulo 16.
- R4: If the tried slot is already held, the channel takes the nearest free slot found by stepping down one slot at a time, with slot 0 wrapping to slot 15. The next channel builds on this adjusted slot.
- R5: For any nonzero `step`, the sixteen slot outputs are pairwise distinct once `done` is 1.
- R6: With `step` = 1, channel k gets slot k and no pull-back ever occurs.
- R7: With `step` = 0, every channel gets slot 0 and no pull-back rule applies.
- R8: With `dir_neg` = 1, the walk starts at channel 15 and goes down. Channel 15-k then gets the slot that channel k gets with `dir_neg` = 0.
- R9: While `done` is 1 and no `start` arrives, the slot outputs hold their values. A `start` pulse while `busy` is 1 is ignored.
- R10: A `start` pulse while `done` is 1 begins a new computation with the newly presented inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (taken when not busy) |
| step | input | 4 | Delay between adjacent channels, in slots |
| dir_neg | input | 1 | 1 = walk from channel 15 downward |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results complete and held |
| slot_o | output | 16x4 | Slot index per channel, element i for channel i |

## Verification
The bound checker watches several properties on every cycle:
- Each slot written during a walk was free beforehand.
- A step of one never triggers a pull-back.
- The busy phase lasts exactly sixteen cycles.
- Once done, a nonzero step leaves all sixteen slots occupied, and a zero step leaves all slots at zero.
- Outputs stay stable while done.

The exact slot value per channel depends on the accumulated pull-back history, so only the bench's scenarios can show it. The bench compares each channel against an independent model for several steps in both directions. It also covers an ignored mid-run strobe and back-to-back restarts.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pdg_state_t;
endpackage

// File: rtl/pdg_seq_ctrl.sv
module pdg_seq_ctrl #(
  parameter int N_CH = 16,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          start_acc,
  output logic          busy,
  output logic          done,
  output logic          first,
  output logic [CW-1:0] idx
);
  import pdg_pkg::*;

  pdg_state_t state;

  assign busy      = (state == ST_RUN);
  assign done      = (state == ST_DONE);
  assign start_acc = start && (state != ST_RUN);
  assign first     = busy && (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (start_acc) begin
      state <= ST_RUN;
      idx   <= '0;
    end else if (state == ST_RUN) begin
      idx <= idx + 1'b1;
      if (idx == CW'(N_CH - 1)) state <= ST_DONE;
    end
  end
endmodule

// File: rtl/pdg_step_unit.sv
module pdg_step_unit #(
  parameter int N_CH = 16,
  localparam int SW = $clog2(N_CH)
) (
  input  logic            first,
  input  logic [SW-1:0]   step,
  input  logic [SW-1:0]   prev,
  input  logic [N_CH-1:0] used,
  output logic [SW-1:0]   slot,
  output logic            skip_evt
);
  function automatic logic [SW-1:0] wrap_add(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [SW-1:0] free_below(input logic [SW-1:0] c, input logic [N_CH-1:0] u);
    logic [SW-1:0] r;
    logic [SW-1:0] t;
    logic          hit;
    r   = c;
    hit = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      t = c - SW'(i);
      if (!hit && !u[t]) begin
        r   = t;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [SW-1:0] cand;
  logic          zero_step;

  assign zero_step = (step == '0);
  assign cand      = first ? '0 : wrap_add(prev, step);
  assign skip_evt  = !first && !zero_step && used[cand];

  always_comb begin
    if (first || zero_step) slot = '0;
    else                    slot = free_below(cand, used);
  end
endmodule

// File: rtl/pdg_slot_table.sv
module pdg_slot_table #(
  parameter int N_CH = 16,
  localparam int SW = $clog2(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [SW-1:0]           wr_ch,
  input  logic [SW-1:0]           wr_slot,
  output logic [N_CH-1:0][SW-1:0] slots,
  output logic [N_CH-1:0]         used
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slots[g] <= '0;
      else if (clear)                      slots[g] <= '0;
      else if (wr_en && wr_ch == SW'(g))   slots[g] <= wr_slot;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          used[g] <= 1'b0;
      else if (clear)                      used[g] <= 1'b0;
      else if (wr_en && wr_slot == SW'(g)) used[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/phased_delay_gen.sv
module phased_delay_gen #(
  parameter int N_CH = 16,
  localparam int SW = $clog2(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SW-1:0]           step,
  input  logic                    dir_neg,
  output logic                    busy,
  output logic                    done,
  output logic [N_CH-1:0][SW-1:0] slot_o
);
  logic            start_acc;
  logic            first;
  logic [SW-1:0]   idx;
  logic [SW-1:0]   step_q;
  logic            dir_q;
  logic [SW-1:0]   prev_q;
  logic [SW-1:0]   new_slot;
  logic            skip_evt;
  logic [N_CH-1:0] used;
  logic [SW-1:0]   wr_ch;

  pdg_seq_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_acc(start_acc),
    .busy(busy), .done(done), .first(first), .idx(idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      dir_q  <= 1'b0;
      prev_q <= '0;
    end else if (start_acc) begin
      step_q <= step;
      dir_q  <= dir_neg;
      prev_q <= '0;
    end else if (busy) begin
      prev_q <= new_slot;
    end
  end

  assign wr_ch = dir_q ? (SW'(N_CH - 1) - idx) : idx;

  pdg_step_unit #(.N_CH(N_CH)) u_step (
    .first(first), .step(step_q), .prev(prev_q), .used(used),
    .slot(new_slot), .skip_evt(skip_evt)
  );

  pdg_slot_table #(.N_CH(N_CH)) u_tab (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .wr_en(busy),
    .wr_ch(wr_ch), .wr_slot(new_slot), .slots(slot_o), .used(used)
  );
endmodule

// File: rtl/phased_delay_gen_chk.sv
module phased_delay_gen_chk #(
  parameter int N_CH = 16,
  localparam int SW = $clog2(N_CH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    start_acc,
  input logic                    busy,
  input logic                    done,
  input logic                    skip_evt,
  input logic [SW-1:0]           step_q,
  input logic [SW-1:0]           new_slot,
  input logic [N_CH-1:0]         used,
  input logic [N_CH-1:0][SW-1:0] slot_o
);
  logic [SW:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (start_acc) run_len <= '0;
    else if (busy)      run_len <= run_len + 1'b1;
  end

  // R2
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> run_len == (SW+1)'(N_CH));
  // R4 / R5
  p_free_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_q != '0) |-> !used[new_slot]);
  p_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && step_q != '0) |-> (used == '1));
  // R6
  p_noskip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_q == SW'(1)) |-> !skip_evt);
  // R7
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && step_q == '0) |-> (slot_o == '0));
  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(slot_o));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(step_q));
endmodule

bind phased_delay_gen phased_delay_gen_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_acc(start_acc),
  .busy(busy), .done(done), .skip_evt(skip_evt), .step_q(step_q),
  .new_slot(new_slot), .used(used), .slot_o(slot_o)
);

// File: tb/phased_delay_gen_test.sv
module phased_delay_gen_test;
  localparam int N = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [3:0]        step = '0;
  logic              dir_neg = 1'b0;
  logic              busy;
  logic              done;
  logic [N-1:0][3:0] slot_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [N-1:0][3:0] s;
    string             tag;
  } exp_t;

  exp_t              sb_q[$];
  logic [N-1:0][3:0] last_exp;

  always #10 clk = ~clk;

  phased_delay_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .dir_neg(dir_neg), .busy(busy), .done(done), .slot_o(slot_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0][3:0] model(input int st, input bit neg);
    logic [N-1:0][3:0] r;
    bit taken[N];
    int pos;
    pos = 0;
    foreach (taken[i]) taken[i] = 0;
    for (int k = 0; k < N; k++) begin
      if (st == 0) begin
        pos = 0;
      end else begin
        if (k > 0) pos = (pos + st) % N;
        while (taken[pos]) pos = (pos + N - 1) % N;
        taken[pos] = 1;
      end
      r[neg ? (N - 1 - k) : k] = 4'(pos);
    end
    return r;
  endfunction

  // monitor: compare on rising done, measure busy length
  logic done_d = 1'b0;
  int   busy_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_len++;
      if (done && !done_d) begin
        if (sb_q.size() == 0) begin
          check(0, "R2 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          last_exp = e.s;
          check(busy_len == N, {e.tag, " R2 busy length"}, busy_len, N);
          for (int c = 0; c < N; c++)
            check(slot_o[c] == e.s[c], $sformatf("%s ch%0d", e.tag, c), slot_o[c], e.s[c]);
        end
        busy_len = 0;
      end
      done_d <= done;
    end
  end

  task automatic run_case(input int st, input bit neg, input string tag, input bit intrude);
    exp_t e;
    e.s   = model(st, neg);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    step = 4'(st); dir_neg = neg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (4) @(negedge clk);
      step = 4'((st + 3) % N); dir_neg = ~neg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(slot_o == '0, "R1 slots", 32'(slot_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(1, 0, "R6 R3 step1", 0);
    run_case(4, 0, "R4 R5 step4", 0);
    run_case(0, 0, "R7 step0", 0);
    run_case(4, 1, "R8 step4 neg", 0);
    run_case(5, 0, "R4 step5", 1);   // R9 mid-run strobe ignored
    // R9: outputs still held after idle time in done
    repeat (10) @(negedge clk);
    for (int c = 0; c < N; c++)
      check(slot_o[c] == last_exp[c], $sformatf("R9 hold ch%0d", c), slot_o[c], last_exp[c]);
    run_case(8, 0, "R10 restart step8", 0);
    run_case(15, 1, "R10 R8 step15 neg", 0);
    run_case(6, 0, "R5 step6", 0);
    run_case(12, 0, "R5 step12", 0);
    check(sb_q.size() == 0, "R2 pending results", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule